// File: doc/BRIEF.md
# Sequential Write Coalescing Qualifier

This block sits beside a storage target's command decoder and decides, command by command, whether an incoming write may be cached. A cached write is reported complete with good status as soon as its data-out transfer ends, and it can be merged with the write before it so the media sees one continuous transfer with no lost spindle revolution. The decoder presents each accepted command for one cycle, with its opcode, first logical block address, length in blocks, the initiator that sent it and its linked flag. The qualifier keeps a one-entry record of the previous write and checks the new command against it.

Merging also depends on timing. After a qualifying write is accepted, a short window opens. The data path must report, within that window, that the first block of the new write has landed in the buffer. If that report does not come in time, merging is refused for that write. Caching as a whole is allowed by a software enable bit, but that bit is overridden when the target runs in tagged-queue mode, where merging is always allowed.

Top module: `seq_write_coalesce_qual`

## Requirements
- R1: While reset is held, and in the first cycle after it, both outputs are 0 and the previous-write record is empty. As a result, the first write after reset never sets `merge_ok`.
- R2: Only opcodes 8'h0A and 8'h2A are writes. Any other opcode (for example 8'h28 or 8'h2E) leaves both outputs at 0 in the cycle after it is accepted.
- R3: Accepting any non-write command empties the previous-write record. A later write that is contiguous with the write before that command does not set `merge_ok`.
- R4: A pair merges only when the new start address equals the previous start address plus the previous block count.
- R5: A pair merges only when both writes carry the same initiator ID.
- R6: A pair merges only when neither write is linked. A linked write also leaves `early_done_ok` at 0.
- R7: If the previous write's start address plus its count exceeds 2^LBA_W - 1, no following write merges with it. A write that ends exactly at the top address still qualifies.
- R8: `block_in_time` is sampled on the WINDOW clock edges that follow the acceptance edge. When it is seen on one of those edges, `merge_ok` is 1 from that edge onwards. The strobe is ignored on the acceptance edge itself and after the window closes.
- R9: Caching is enabled when `cache_en` is 1 or `queue_mode` is 1, sampled at acceptance. With caching disabled, both outputs stay at 0.
- R10: `early_done_ok` is 1 from the acceptance edge of a non-linked write accepted while caching is enabled.
- R11: Both outputs hold their values until the next command is accepted. That acceptance replaces them on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is accepted this cycle |
| cmd_opcode | input | 8 | Operation code of the command |
| cmd_lba | input | LBA_W | First logical block address |
| cmd_blocks | input | CNT_W | Transfer length in blocks |
| cmd_src_id | input | ID_W | Initiator that sent the command |
| cmd_linked | input | 1 | Command is linked to the next one |
| cache_en | input | 1 | Software write-cache enable |
| queue_mode | input | 1 | Tagged-queue mode active; forces caching on |
| block_in_time | input | 1 | First block of the current write reached the buffer |
| merge_ok | output | 1 | Current write may be merged with the previous one |
| early_done_ok | output | 1 | Current write may report completion after data-out |

## Verification
`early_done_ok` is settled one edge after acceptance. The bench therefore reads it on the falling edge right after the acceptance cycle. `merge_ok` is settled on the edge that samples `block_in_time`. The bench reads it on the falling edge after the strobe cycle, and it places the strobe on the first edge of the window, on the last edge, one edge beyond the last, and on the acceptance edge itself. A hold check waits several idle cycles and confirms that both outputs stay where acceptance left them.

// File: rtl/wcq_pkg.sv
// Package: shared constants and types for the write coalescing qualifier.
// Assumes opcodes are 8 bits wide; the write opcode list is packed LSB-first.
package wcq_pkg;

    localparam int OPC_W     = 8;
    localparam int N_WR_OPS  = 2;
    // Write opcodes, entry i at bits [i*8 +: 8].
    localparam logic [N_WR_OPS*OPC_W-1:0] WR_OPS = {8'h2A, 8'h0A};

    // States of the data-arrival window.
    typedef enum logic [0:0] {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

endpackage

// File: rtl/wcq_opdecode.sv
// Module: wcq_opdecode
// Flags whether an opcode is one of the write opcodes listed in wcq_pkg.
// Purely combinational; assumes the opcode is stable while it is evaluated.
module wcq_opdecode
    import wcq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             is_write
);

    logic [N_WR_OPS-1:0] match;

    // One comparator per listed write opcode.
    for (genvar i = 0; i < N_WR_OPS; i++) begin : g_match
        assign match[i] = (opcode == WR_OPS[i*OPC_W +: OPC_W]);
    end

    // Any comparator hit marks a write.
    assign is_write = |match;

endmodule

// File: rtl/wcq_record.sv
// Module: wcq_record
// Keeps the previous write (the address after its last block, its initiator,
// its linked flag and whether its end passed the top address). It compares
// the presented command against that write. pair_ok is combinational and is
// only meaningful when accept is high. Assumes one command per accept pulse.
module wcq_record #(
    parameter int LBA_W = 32,
    parameter int CNT_W = 16,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             is_write,
    input  logic [LBA_W-1:0] lba,
    input  logic [CNT_W-1:0] blocks,
    input  logic [ID_W-1:0]  src_id,
    input  logic             linked,
    output logic             pair_ok
);

    localparam int SUM_W = LBA_W + 1;

    logic             rec_valid;
    logic [LBA_W-1:0] rec_next;
    logic             rec_wrap;
    logic [ID_W-1:0]  rec_id;
    logic             rec_linked;
    logic [SUM_W-1:0] end_sum;

    // Address after the presented command's last block, carry included.
    assign end_sum = {1'b0, lba} + SUM_W'(blocks);

    // Every condition that ties the new write to the stored one.
    always_comb begin
        pair_ok = rec_valid && !rec_wrap && !rec_linked
               && is_write && !linked
               && (src_id == rec_id)
               && (lba == rec_next);
    end

    // Store each accepted write; drop the record on any other command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid  <= 1'b0;
            rec_next   <= '0;
            rec_wrap   <= 1'b0;
            rec_id     <= '0;
            rec_linked <= 1'b0;
        end else if (accept) begin
            if (is_write) begin
                rec_valid  <= 1'b1;
                rec_next   <= end_sum[LBA_W-1:0];
                rec_wrap   <= end_sum[LBA_W];
                rec_id     <= src_id;
                rec_linked <= linked;
            end else begin
                rec_valid  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wcq_window.sv
// Module: wcq_window
// Data-arrival deadline. start opens a window of WINDOW edges. hit is high
// while the window is open and the strobe is present. The window closes on a
// hit, on expiry or on cancel. Assumes start and cancel are never high together.
module wcq_window
    import wcq_pkg::*;
#(
    parameter int WINDOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    input  logic strobe,
    output logic hit
);

    localparam int CYC_W = $clog2(WINDOW + 1);

    win_state_t       state;
    logic [CYC_W-1:0] left;

    // Strobe counts only inside an open window.
    assign hit = (state == WIN_OPEN) && strobe;

    // Open, count down and close the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WIN_IDLE;
            left  <= '0;
        end else if (start) begin
            state <= WIN_OPEN;
            left  <= CYC_W'(WINDOW);
        end else if (cancel) begin
            state <= WIN_IDLE;
        end else if (state == WIN_OPEN) begin
            if (strobe || left == CYC_W'(1)) begin
                state <= WIN_IDLE;
            end else begin
                left  <= left - CYC_W'(1);
            end
        end
    end

endmodule

// File: rtl/seq_write_coalesce_qual.sv
// Module: seq_write_coalesce_qual
// Top of the qualifier. On each accepted command it decodes the opcode and
// checks the command against the previous write. It sets the early-completion
// flag for that command, and it opens the arrival window when the pair may merge.
// Assumes cmd_valid is a one-cycle pulse per command and that block_in_time
// refers to the most recently accepted write.
module seq_write_coalesce_qual
    import wcq_pkg::*;
#(
    parameter int LBA_W  = 32,
    parameter int CNT_W  = 16,
    parameter int ID_W   = 4,
    parameter int WINDOW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [OPC_W-1:0] cmd_opcode,
    input  logic [LBA_W-1:0] cmd_lba,
    input  logic [CNT_W-1:0] cmd_blocks,
    input  logic [ID_W-1:0]  cmd_src_id,
    input  logic             cmd_linked,
    input  logic             cache_en,
    input  logic             queue_mode,
    input  logic             block_in_time,
    output logic             merge_ok,
    output logic             early_done_ok
);

    logic is_write;
    logic pair_ok;
    logic caching_on;
    logic qualify;
    logic early_next;
    logic win_hit;

    wcq_opdecode u_dec (
        .opcode   (cmd_opcode),
        .is_write (is_write)
    );

    wcq_record #(
        .LBA_W (LBA_W),
        .CNT_W (CNT_W),
        .ID_W  (ID_W)
    ) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (cmd_valid),
        .is_write (is_write),
        .lba      (cmd_lba),
        .blocks   (cmd_blocks),
        .src_id   (cmd_src_id),
        .linked   (cmd_linked),
        .pair_ok  (pair_ok)
    );

    // Queue mode overrides the software enable.
    assign caching_on = queue_mode || cache_en;
    assign early_next = is_write && !cmd_linked && caching_on;
    assign qualify    = pair_ok && caching_on;

    wcq_window #(
        .WINDOW (WINDOW)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cmd_valid && qualify),
        .cancel (cmd_valid && !qualify),
        .strobe (block_in_time),
        .hit    (win_hit)
    );

    // Output flags: replaced on acceptance, merge raised on an in-time strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merge_ok      <= 1'b0;
            early_done_ok <= 1'b0;
        end else if (cmd_valid) begin
            merge_ok      <= 1'b0;
            early_done_ok <= early_next;
        end else if (win_hit) begin
            merge_ok      <= 1'b1;
        end
    end

endmodule

// File: rtl/wcq_checker.sv
// Module: wcq_checker
// Port-level properties of the qualifier, attached to the top by bind.
module wcq_checker
    import wcq_pkg::*;
#(
    parameter int LBA_W  = 32,
    parameter int CNT_W  = 16,
    parameter int ID_W   = 4,
    parameter int WINDOW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [OPC_W-1:0] cmd_opcode,
    input logic [LBA_W-1:0] cmd_lba,
    input logic [CNT_W-1:0] cmd_blocks,
    input logic [ID_W-1:0]  cmd_src_id,
    input logic             cmd_linked,
    input logic             cache_en,
    input logic             queue_mode,
    input logic             block_in_time,
    input logic             merge_ok,
    input logic             early_done_ok
);

    logic opc_write;
    assign opc_write = (cmd_opcode == 8'h0A) || (cmd_opcode == 8'h2A);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!merge_ok && !early_done_ok));

    // R2
    non_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !opc_write) |=> (!merge_ok && !early_done_ok));

    // R6
    linked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_linked) |=> (!merge_ok && !early_done_ok));

    // R9
    cache_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cache_en && !queue_mode) |=> (!merge_ok && !early_done_ok));

    // R8
    merge_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(merge_ok) |-> $past(block_in_time));

    // R10
    merge_implies_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        merge_ok |-> early_done_ok);

    // R11
    merge_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && merge_ok) |=> merge_ok);

    // R11
    early_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(early_done_ok));

endmodule

bind seq_write_coalesce_qual wcq_checker #(
    .LBA_W  (LBA_W),
    .CNT_W  (CNT_W),
    .ID_W   (ID_W),
    .WINDOW (WINDOW)
) u_chk (.*);

// File: tb/seq_write_coalesce_qual_bench.sv
// Directed bench for the write coalescing qualifier. Inputs change on the
// falling edge and outputs are read on the falling edge.
module seq_write_coalesce_qual_bench;

    localparam int LBA_W  = 32;
    localparam int CNT_W  = 16;
    localparam int ID_W   = 4;
    localparam int WINDOW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [7:0]       cmd_opcode = '0;
    logic [LBA_W-1:0] cmd_lba = '0;
    logic [CNT_W-1:0] cmd_blocks = '0;
    logic [ID_W-1:0]  cmd_src_id = '0;
    logic             cmd_linked = 1'b0;
    logic             cache_en = 1'b1;
    logic             queue_mode = 1'b0;
    logic             block_in_time = 1'b0;
    logic             merge_ok;
    logic             early_done_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seq_write_coalesce_qual #(
        .LBA_W (LBA_W), .CNT_W (CNT_W), .ID_W (ID_W), .WINDOW (WINDOW)
    ) u_seq_write_coalesce_qual (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid),
        .cmd_opcode (cmd_opcode), .cmd_lba (cmd_lba), .cmd_blocks (cmd_blocks),
        .cmd_src_id (cmd_src_id), .cmd_linked (cmd_linked), .cache_en (cache_en),
        .queue_mode (queue_mode), .block_in_time (block_in_time),
        .merge_ok (merge_ok), .early_done_ok (early_done_ok)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one command for a single cycle; returns one falling edge later.
    task automatic issue(input logic [7:0] op, input logic [LBA_W-1:0] lba,
                         input logic [CNT_W-1:0] n, input logic [ID_W-1:0] id,
                         input logic lnk, input logic strobe_too = 1'b0);
        cmd_valid = 1'b1; cmd_opcode = op; cmd_lba = lba;
        cmd_blocks = n; cmd_src_id = id; cmd_linked = lnk;
        block_in_time = strobe_too;
        @(negedge clk);
        cmd_valid = 1'b0; block_in_time = 1'b0;
    endtask

    // Strobe on window edge delay+1; returns one falling edge later.
    task automatic strobe(input int delay);
        repeat (delay) @(negedge clk);
        block_in_time = 1'b1;
        @(negedge clk);
        block_in_time = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 merge in reset", merge_ok, 1'b0);
        check("R1 early in reset", early_done_ok, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 merge after reset", merge_ok, 1'b0);
        issue(8'h2A, 32'd100, 16'd8, 4'd2, 1'b0);
        check("R10 early on write", early_done_ok, 1'b1);
        strobe(0);
        check("R1 first write does not merge", merge_ok, 1'b0);
    endtask

    task automatic t_basic;
        issue(8'h0A, 32'd108, 16'd4, 4'd2, 1'b0);
        strobe(0);
        check("R4 contiguous pair merges", merge_ok, 1'b1);
        check("R2 opcode 0A after 2A", early_done_ok, 1'b1);
        repeat (4) @(negedge clk);
        check("R11 merge held while idle", merge_ok, 1'b1);
        check("R11 early held while idle", early_done_ok, 1'b1);
        issue(8'h28, 32'd112, 16'd4, 4'd2, 1'b0);
        check("R11 merge replaced by next command", merge_ok, 1'b0);
        check("R2 read has no early", early_done_ok, 1'b0);
        issue(8'h2A, 32'd112, 16'd4, 4'd2, 1'b0);
        strobe(0);
        check("R3 record cleared by read", merge_ok, 1'b0);
    endtask

    task automatic t_opcode;
        issue(8'h2A, 32'd200, 16'd4, 4'd1, 1'b0);
        issue(8'h2E, 32'd204, 16'd4, 4'd1, 1'b0);
        check("R2 opcode 2E early", early_done_ok, 1'b0);
        strobe(0);
        check("R2 opcode 2E merge", merge_ok, 1'b0);
    endtask

    task automatic t_contig_id;
        issue(8'h2A, 32'd300, 16'd4, 4'd1, 1'b0);
        issue(8'h2A, 32'd305, 16'd4, 4'd1, 1'b0);
        strobe(0);
        check("R4 gap of one block", merge_ok, 1'b0);
        issue(8'h2A, 32'd309, 16'd2, 4'd1, 1'b0);
        strobe(0);
        check("R4 contiguous after gap", merge_ok, 1'b1);
        issue(8'h2A, 32'd311, 16'd4, 4'd3, 1'b0);
        strobe(0);
        check("R5 other initiator", merge_ok, 1'b0);
        issue(8'h2A, 32'd315, 16'd4, 4'd3, 1'b0);
        strobe(0);
        check("R5 same initiator", merge_ok, 1'b1);
    endtask

    task automatic t_linked;
        issue(8'h2A, 32'd500, 16'd4, 4'd1, 1'b1);
        check("R6 linked write no early", early_done_ok, 1'b0);
        issue(8'h2A, 32'd504, 16'd4, 4'd1, 1'b0);
        strobe(0);
        check("R6 previous linked", merge_ok, 1'b0);
        issue(8'h0A, 32'd508, 16'd4, 4'd1, 1'b1);
        strobe(0);
        check("R6 current linked", merge_ok, 1'b0);
    endtask

    task automatic t_window;
        issue(8'h2A, 32'd700, 16'd4, 4'd5, 1'b0);
        issue(8'h2A, 32'd704, 16'd4, 4'd5, 1'b0);
        strobe(WINDOW - 1);
        check("R8 strobe on last window edge", merge_ok, 1'b1);
        issue(8'h2A, 32'd708, 16'd4, 4'd5, 1'b0);
        strobe(WINDOW);
        check("R8 strobe one edge late", merge_ok, 1'b0);
        issue(8'h2A, 32'd712, 16'd4, 4'd5, 1'b0, 1'b1);
        repeat (WINDOW + 2) @(negedge clk);
        check("R8 strobe on acceptance edge ignored", merge_ok, 1'b0);
    endtask

    task automatic t_enable;
        cache_en = 1'b0; queue_mode = 1'b0;
        issue(8'h2A, 32'd800, 16'd4, 4'd6, 1'b0);
        issue(8'h2A, 32'd804, 16'd4, 4'd6, 1'b0);
        check("R9 disabled no early", early_done_ok, 1'b0);
        strobe(0);
        check("R9 disabled no merge", merge_ok, 1'b0);
        queue_mode = 1'b1;
        issue(8'h2A, 32'd808, 16'd4, 4'd6, 1'b0);
        check("R9 queue mode early", early_done_ok, 1'b1);
        strobe(1);
        check("R9 queue mode overrides enable", merge_ok, 1'b1);
        cache_en = 1'b1; queue_mode = 1'b0;
    endtask

    task automatic t_wrap;
        issue(8'h2A, 32'hFFFF_FFF0, 16'd8, 4'd7, 1'b0);
        issue(8'h2A, 32'hFFFF_FFF8, 16'd8, 4'd7, 1'b0);
        strobe(0);
        check("R7 write ending at top address", merge_ok, 1'b1);
        issue(8'h2A, 32'h0000_0000, 16'd4, 4'd7, 1'b0);
        strobe(0);
        check("R7 wrap disqualifies", merge_ok, 1'b0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_opcode();
        t_contig_id();
        t_linked();
        t_window();
        t_enable();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule